// File: doc/BRIEF.md
# Memory-Mapped BCD Calendar Clock

This block keeps time of day and a calendar in binary-coded decimal and shows them to a host as eight byte registers at the top of a byte-addressed window (offsets 1FF8h to 1FFFh). The host reads and writes these bytes like ordinary RAM, through a synchronous model of a byte bus with active-low chip-enable, output-enable and write-enable strobes. The block does not decode the rest of the window below 1FF8h.

The running time is held in separate internal counters. These advance once per second, on a tick made by dividing a reference enable pulse (nominally 32,768 Hz) by `REF_DIV`. One cycle after the counters advance, their values are copied into the host-visible bytes. The byte at 1FF8h is a control register. Bit 7 halts the copy so that a multi-byte read is coherent, while the counters keep running. Bit 6 stops counting so the host can write a new time; clearing it loads the written bytes into the counters. Bits 5..0 hold a calibration field that is only stored.

Top module: `rtc_bcd_clock`

## Requirements
- R1: After reset the window reads, from offset 0 to 7: control 00h, seconds 00h, minutes 00h, hours 00h, day 01h, date 01h, month 01h, year 00h.
- R2: A read takes place on an edge where `ce_n`=0 and `we_n`=1 with `addr` in 1FF8h..1FFFh. The addressed byte appears on `rdata` one cycle later, and `rdata_oe` is 1 in that cycle only if `oe_n` was also 0. Any other cycle gives `rdata_oe`=0, and a read outside the window gives `rdata`=00h.
- R3: A write takes place on an edge where `ce_n`=0 and `we_n`=0 with `addr` in the window, and stores `wdata` in byte `addr[2:0]`. A write with `ce_n`=1 or with `addr` outside the window changes no byte. A host write wins over a copy to the same byte in the same cycle.
- R4: Each `REF_DIV` edges with `ref_en`=1 give one tick. The counters advance on the edge after the tick, and the bytes take the new values on the edge after that.
- R5: Seconds and minutes count 00..59 and hours count 00..23 in BCD. The day of week and the date advance when the hours wrap.
- R6: The date wraps to 01 and the month advances after 30 in April, June, September and November, and after 31 in the other months except February.
- R7: February ends on 29 when the BCD year is divisible by 4 (00 included), and on 28 otherwise.
- R8: The month wraps from 12 to 01 and advances the year. The year wraps from 99 to 00. The day of week counts 1..7 and wraps to 1.
- R9: While control bit 7 is 1, copies to bytes 1..7 are suppressed and the counters keep advancing. The first copy after it clears shows the advanced time.
- R10: While control bit 6 is 1, the counters and the tick divider stay still and no copy happens. On the edge after it clears, bytes 1..7 load into the counters, and the divider restarts from zero.
- R11: Control bits 5..0 are stored and read back unchanged, and they have no effect on the tick rate. The control byte changes only through host writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_en | input | 1 | One-cycle pulse per reference oscillator period |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| rdata_oe | output | 1 | Read data is being driven |

## Verification
Read data and its drive flag are due one cycle after the strobe edge. A tick is due on the edge of the `REF_DIV`-th reference pulse, the counters move one edge later, and the host-visible bytes one edge after that. The reference model in the bench advances on the same edges and compares the bus outputs at every falling edge. The directed checks send a fixed number of reference pulses and then wait four idle cycles before reading, so every copy has landed by the time a byte is read.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef struct packed {
    logic [7:0] year;
    logic [7:0] month;
    logic [7:0] date;
    logic [7:0] day;
    logic [7:0] hour;
    logic [7:0] minute;
    logic [7:0] second;
  } rtc_time_t;

  localparam int TIME_BYTES = 7;

  function automatic rtc_time_t time_at_reset();
    rtc_time_t t;
    t.year   = 8'h00;
    t.month  = 8'h01;
    t.date   = 8'h01;
    t.day    = 8'h01;
    t.hour   = 8'h00;
    t.minute = 8'h00;
    t.second = 8'h00;
    return t;
  endfunction

  // BCD +1 on a two-digit value; the caller handles the upper limit
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // divisible by four: even tens with ones 0/4/8, odd tens with ones 2/6
  function automatic logic leap_year(input logic [7:0] y);
    if (!y[4]) return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
  endfunction

  function automatic logic [7:0] month_len(input logic [7:0] m, input logic [7:0] y);
    case (m)
      8'h02:                     return leap_year(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                   return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_tick_div.sv
module rtc_tick_div #(
  parameter int DIV = 32768
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_en,
  input  logic hold,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (ref_en) begin
      if (cnt == LAST) begin
        cnt  <= '0;
        tick <= 1'b1;
      end else begin
        cnt  <= cnt + 1'b1;
        tick <= 1'b0;
      end
    end else begin
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core
  import rtc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      tick,
  input  logic      stop,
  input  rtc_time_t load_val,
  output rtc_time_t cnt_o
);
  rtc_time_t cur, nxt;
  logic      stop_q;
  logic      load;

  assign load  = stop_q && !stop;
  assign cnt_o = cur;

  always_comb begin
    nxt = cur;
    if (cur.second >= 8'h59) begin
      nxt.second = 8'h00;
      if (cur.minute >= 8'h59) begin
        nxt.minute = 8'h00;
        if (cur.hour >= 8'h23) begin
          nxt.hour = 8'h00;
          nxt.day  = (cur.day >= 8'h07) ? 8'h01 : bcd_inc(cur.day);
          if (cur.date >= month_len(cur.month, cur.year)) begin
            nxt.date = 8'h01;
            if (cur.month >= 8'h12) begin
              nxt.month = 8'h01;
              nxt.year  = (cur.year >= 8'h99) ? 8'h00 : bcd_inc(cur.year);
            end else begin
              nxt.month = bcd_inc(cur.month);
            end
          end else begin
            nxt.date = bcd_inc(cur.date);
          end
        end else begin
          nxt.hour = bcd_inc(cur.hour);
        end
      end else begin
        nxt.minute = bcd_inc(cur.minute);
      end
    end else begin
      nxt.second = bcd_inc(cur.second);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur    <= time_at_reset();
      stop_q <= 1'b0;
    end else begin
      stop_q <= stop;
      if (load)              cur <= load_val;
      else if (tick && !stop) cur <= nxt;
    end
  end
endmodule

// File: rtl/rtc_reg_bank.sv
module rtc_reg_bank
  import rtc_pkg::*;
#(
  parameter int              ADDR_W = 13,
  parameter logic [ADDR_W-1:0] BASE = 13'h1FF8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              copy_req,
  input  rtc_time_t         cnt_in,
  output logic [7:0]        rdata,
  output logic              rdata_oe,
  output logic [7:0]        ctrl_o,
  output rtc_time_t         time_o
);
  localparam int NB = TIME_BYTES + 1;
  localparam int IW = $clog2(NB);

  logic [7:0] regs [0:NB-1];
  logic [7:0] cnt_bytes [0:NB-1];
  logic [7:0] rst_bytes [0:NB-1];
  logic       in_win, wr_hit, rd_hit, copy_en;
  logic [IW-1:0] idx;
  rtc_time_t  rst_t;

  assign rst_t  = time_at_reset();
  assign in_win = (addr[ADDR_W-1:IW] == BASE[ADDR_W-1:IW]);
  assign idx    = addr[IW-1:0];
  assign wr_hit = !ce_n && !we_n && in_win;
  assign rd_hit = !ce_n && we_n && in_win;
  assign ctrl_o = regs[0];
  assign copy_en = copy_req && !regs[0][7] && !regs[0][6];

  assign cnt_bytes[0] = 8'h00;
  assign rst_bytes[0] = 8'h00;

  genvar g;
  generate
    for (g = 1; g < NB; g++) begin : g_byte
      assign cnt_bytes[g]       = cnt_in[8*g-1 -: 8];
      assign rst_bytes[g]       = rst_t[8*g-1 -: 8];
      assign time_o[8*g-1 -: 8] = regs[g];

      always_ff @(posedge clk) begin
        if (rst)                            regs[g] <= rst_bytes[g];
        else if (wr_hit && idx == IW'(g))   regs[g] <= wdata;
        else if (copy_en)                   regs[g] <= cnt_bytes[g];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)                        regs[0] <= rst_bytes[0];
    else if (wr_hit && idx == '0)   regs[0] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= 8'h00;
      rdata_oe <= 1'b0;
    end else begin
      rdata    <= rd_hit ? regs[idx] : 8'h00;
      rdata_oe <= rd_hit && !oe_n;
    end
  end
endmodule

// File: rtl/rtc_bcd_clock.sv
module rtc_bcd_clock
  import rtc_pkg::*;
#(
  parameter int                ADDR_W   = 13,
  parameter logic [ADDR_W-1:0] CLK_BASE = 13'h1FF8,
  parameter int                REF_DIV  = 32768
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_en,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              rdata_oe
);
  logic      tick_q, tick_d;
  logic [7:0] ctrl_q;
  rtc_time_t cnt_q, time_q;

  rtc_tick_div #(.DIV(REF_DIV)) u_div (
    .clk(clk), .rst(rst), .ref_en(ref_en), .hold(ctrl_q[6]), .tick(tick_q)
  );

  rtc_time_core u_core (
    .clk(clk), .rst(rst), .tick(tick_q), .stop(ctrl_q[6]),
    .load_val(time_q), .cnt_o(cnt_q)
  );

  always_ff @(posedge clk) begin
    if (rst) tick_d <= 1'b0;
    else     tick_d <= tick_q;
  end

  rtc_reg_bank #(.ADDR_W(ADDR_W), .BASE(CLK_BASE)) u_regs (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .wdata(wdata), .copy_req(tick_d), .cnt_in(cnt_q),
    .rdata(rdata), .rdata_oe(rdata_oe), .ctrl_o(ctrl_q), .time_o(time_q)
  );
endmodule

// File: rtl/rtc_bcd_clock_chk.sv
module rtc_bcd_clock_chk #(
  parameter int                ADDR_W = 13,
  parameter logic [ADDR_W-1:0] BASE   = 13'h1FF8
) (
  input logic              clk,
  input logic              rst,
  input logic              ce_n,
  input logic              oe_n,
  input logic              we_n,
  input logic [ADDR_W-1:0] addr,
  input logic              rdata_oe,
  input logic              tick,
  input logic [7:0]        ctrl,
  input logic [55:0]       regs_time,
  input logic [55:0]       cnt
);
  logic win, wr_win, rd_drv;
  assign win    = (addr[ADDR_W-1:3] == BASE[ADDR_W-1:3]);
  assign wr_win = !ce_n && !we_n && win;
  assign rd_drv = !ce_n && we_n && !oe_n && win;

  // R2
  rd_drive_chk: assert property (@(posedge clk) disable iff (rst) rd_drv |=> rdata_oe);
  // R2
  rd_quiet_chk: assert property (@(posedge clk) disable iff (rst) !rd_drv |=> !rdata_oe);
  // R11
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (rst) !wr_win |=> $stable(ctrl));
  // R9
  halt_freeze_chk: assert property (@(posedge clk) disable iff (rst) (ctrl[7] && !wr_win) |=> $stable(regs_time));
  // R10
  stop_freeze_chk: assert property (@(posedge clk) disable iff (rst) ctrl[6] |=> $stable(cnt));
  // R4
  tick_gap_chk: assert property (@(posedge clk) disable iff (rst) tick |=> !tick);
  // R4
  cnt_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !($past(ctrl[6]) && !ctrl[6])) |=> $stable(cnt));
endmodule

bind rtc_bcd_clock rtc_bcd_clock_chk #(.ADDR_W(ADDR_W), .BASE(CLK_BASE)) u_chk (
  .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .addr(addr),
  .rdata_oe(rdata_oe), .tick(tick_q), .ctrl(ctrl_q), .regs_time(time_q), .cnt(cnt_q)
);

// File: tb/sim_rtc_bcd_clock.sv
module sim_rtc_bcd_clock;
  localparam int          DIV  = 4;
  localparam logic [12:0] BASE = 13'h1FF8;

  logic clk = 1'b0, rst = 1'b1, ref_en = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [12:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        rdata_oe;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rtc_bcd_clock #(.ADDR_W(13), .CLK_BASE(BASE), .REF_DIV(DIV)) u0 (
    .clk(clk), .rst(rst), .ref_en(ref_en), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
  );

  // ---------------- reference model ----------------
  int m_div; bit m_tick, m_tick_d, m_stopq, m_oe;
  int mt[1:7];              // 1 sec 2 min 3 hour 4 day 5 date 6 month 7 year (binary)
  logic [7:0] mr[0:7], nr[0:7], m_rd;

  function automatic logic [7:0] to_bcd(input int v); return 8'((v / 10) * 16 + v % 10); endfunction
  function automatic int from_bcd(input logic [7:0] b); return int'(b[7:4]) * 10 + int'(b[3:0]); endfunction
  function automatic int mlen(input int mo, input int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic advance();
    mt[1]++;
    if (mt[1] < 60) return;
    mt[1] = 0; mt[2]++;
    if (mt[2] < 60) return;
    mt[2] = 0; mt[3]++;
    if (mt[3] < 24) return;
    mt[3] = 0;
    mt[4] = (mt[4] == 7) ? 1 : mt[4] + 1;
    mt[5]++;
    if (mt[5] <= mlen(mt[6], mt[7])) return;
    mt[5] = 1; mt[6]++;
    if (mt[6] <= 12) return;
    mt[6] = 1; mt[7] = (mt[7] == 99) ? 0 : mt[7] + 1;
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_div = 0; m_tick = 0; m_tick_d = 0; m_stopq = 0; m_oe = 0; m_rd = 8'h00;
      mt[1] = 0; mt[2] = 0; mt[3] = 0; mt[4] = 1; mt[5] = 1; mt[6] = 1; mt[7] = 0;
      for (int i = 0; i < 8; i++) mr[i] = 8'h00;
      mr[4] = 8'h01; mr[5] = 8'h01; mr[6] = 8'h01;
    end else begin
      bit stop, halt, win;
      stop = mr[0][6]; halt = mr[0][7];
      win  = (addr[12:3] == BASE[12:3]);
      for (int i = 0; i < 8; i++) nr[i] = mr[i];
      if (m_tick_d && !halt && !stop)
        for (int k = 1; k < 8; k++) nr[k] = to_bcd(mt[k]);
      if (!ce_n && !we_n && win) nr[addr[2:0]] = wdata;
      if (!ce_n && we_n && win) begin m_rd = mr[addr[2:0]]; m_oe = !oe_n; end
      else begin m_rd = 8'h00; m_oe = 0; end
      if (m_stopq && !stop) for (int k = 1; k < 8; k++) mt[k] = from_bcd(mr[k]);
      else if (m_tick && !stop) advance();
      m_tick_d = m_tick;
      if (stop) begin m_div = 0; m_tick = 0; end
      else if (ref_en) begin
        if (m_div == DIV - 1) begin m_div = 0; m_tick = 1; end
        else begin m_div++; m_tick = 0; end
      end else m_tick = 0;
      m_stopq = stop;
      for (int i = 0; i < 8; i++) mr[i] = nr[i];
    end
  end

  // R2: bus outputs against the model on every clock
  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (rdata_oe !== m_oe || rdata !== m_rd) begin
        errors++;
        $display("FAIL R2 model compare: actual oe=%0b data=%h expected oe=%0b data=%h",
                 rdata_oe, rdata, m_oe, m_rd);
      end
    end
  end

  // ---------------- tasks ----------------
  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [12:0] a, input logic [7:0] d);
    @(negedge clk); ce_n = 0; we_n = 0; addr = a; wdata = d;
    @(negedge clk); ce_n = 1; we_n = 1;
  endtask

  task automatic rd(input logic [2:0] i, output logic [7:0] v, output logic oe);
    @(negedge clk); ce_n = 0; we_n = 1; oe_n = 0; addr = BASE + 13'(i);
    @(negedge clk); v = rdata; oe = rdata_oe; ce_n = 1; oe_n = 1;
  endtask

  task automatic expect_byte(input string tag, input logic [2:0] i, input logic [7:0] exp);
    logic [7:0] v; logic oe;
    rd(i, v, oe);
    check(tag, v, exp);
  endtask

  task automatic pulse_ref(input int n);
    repeat (n) begin @(negedge clk); ref_en = 1; end
    @(negedge clk); ref_en = 0;
    repeat (4) @(negedge clk);
  endtask

  // order: sec, min, hour, day, date, month, year
  task automatic set_time(input logic [7:0] s, mi, h, dw, dt, mo, y);
    wr(BASE, 8'h40);
    wr(BASE + 1, s);  wr(BASE + 2, mi); wr(BASE + 3, h);
    wr(BASE + 4, dw); wr(BASE + 5, dt); wr(BASE + 6, mo); wr(BASE + 7, y);
    wr(BASE, 8'h00);
    repeat (2) @(negedge clk);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    logic [7:0] v; logic oe;
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1
    expect_byte("R1 ctrl", 0, 8'h00);  expect_byte("R1 sec", 1, 8'h00);
    expect_byte("R1 min", 2, 8'h00);   expect_byte("R1 hour", 3, 8'h00);
    expect_byte("R1 day", 4, 8'h01);   expect_byte("R1 date", 5, 8'h01);
    expect_byte("R1 month", 6, 8'h01); expect_byte("R1 year", 7, 8'h00);

    // R2: oe_n high, and outside window
    @(negedge clk); ce_n = 0; we_n = 1; oe_n = 1; addr = BASE + 13'd5;
    @(negedge clk); check("R2 oe_n high no drive", {7'd0, rdata_oe}, 8'h00); ce_n = 1;
    @(negedge clk); ce_n = 0; we_n = 1; oe_n = 0; addr = 13'h0010;
    @(negedge clk); check("R2 outside oe", {7'd0, rdata_oe}, 8'h00);
    check("R2 outside data", rdata, 8'h00); ce_n = 1; oe_n = 1;
    rd(3'd4, v, oe); check("R2 in-window oe", {7'd0, oe}, 8'h01);

    // R4
    pulse_ref(3 * DIV);
    expect_byte("R4 three seconds", 1, 8'h03);
    pulse_ref(DIV - 1);
    expect_byte("R4 partial period no tick", 1, 8'h03);
    pulse_ref(1);
    expect_byte("R4 period completes", 1, 8'h04);

    // R5
    set_time(8'h58, 8'h59, 8'h23, 8'h02, 8'h15, 8'h01, 8'h21);
    pulse_ref(2 * DIV);
    expect_byte("R5 sec wrap", 1, 8'h00); expect_byte("R5 min wrap", 2, 8'h00);
    expect_byte("R5 hour wrap", 3, 8'h00); expect_byte("R5 day step", 4, 8'h03);
    expect_byte("R5 date step", 5, 8'h16);
    set_time(8'h59, 8'h09, 8'h09, 8'h02, 8'h15, 8'h01, 8'h21);
    pulse_ref(DIV);
    expect_byte("R5 bcd minute carry", 2, 8'h10); expect_byte("R5 hour kept", 3, 8'h09);

    // R6
    set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h30, 8'h04, 8'h21);
    pulse_ref(DIV);
    expect_byte("R6 april end date", 5, 8'h01); expect_byte("R6 april end month", 6, 8'h05);
    set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h30, 8'h01, 8'h21);
    pulse_ref(DIV);
    expect_byte("R6 january 31", 5, 8'h31); expect_byte("R6 january kept", 6, 8'h01);

    // R7
    set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h04);
    pulse_ref(DIV);
    expect_byte("R7 leap feb 29", 5, 8'h29); expect_byte("R7 leap month", 6, 8'h02);
    set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h03);
    pulse_ref(DIV);
    expect_byte("R7 common mar 1", 5, 8'h01); expect_byte("R7 common month", 6, 8'h03);
    set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h00);
    pulse_ref(DIV);
    expect_byte("R7 year 00 leap", 5, 8'h29);

    // R8
    set_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
    pulse_ref(DIV);
    expect_byte("R8 year wrap", 7, 8'h00); expect_byte("R8 month wrap", 6, 8'h01);
    expect_byte("R8 date wrap", 5, 8'h01); expect_byte("R8 day wrap", 4, 8'h01);

    // R9
    set_time(8'h10, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    wr(BASE, 8'h80);
    pulse_ref(3 * DIV);
    expect_byte("R9 halted copy", 1, 8'h10);
    wr(BASE, 8'h00);
    pulse_ref(DIV);
    expect_byte("R9 counters kept running", 1, 8'h14);

    // R10
    wr(BASE, 8'h40);
    wr(BASE + 1, 8'h30);
    pulse_ref(5 * DIV);
    expect_byte("R10 stopped sec", 1, 8'h30);
    expect_byte("R10 stopped min", 2, 8'h00);
    wr(BASE, 8'h00);
    pulse_ref(DIV);
    expect_byte("R10 loaded and resumed", 1, 8'h31);

    // R11
    wr(BASE, 8'h2A);
    expect_byte("R11 cal readback", 0, 8'h2A);
    pulse_ref(DIV);
    expect_byte("R11 rate unchanged", 1, 8'h32);
    wr(BASE, 8'h15);
    expect_byte("R11 cal readback 2", 0, 8'h15);

    // R3
    wr(13'h0FF9, 8'h55);
    expect_byte("R3 outside write ignored", 1, 8'h32);
    @(negedge clk); ce_n = 1; we_n = 0; addr = BASE + 13'd2; wdata = 8'h44;
    @(negedge clk); we_n = 1;
    expect_byte("R3 ce_n high write ignored", 2, 8'h00);
    wr(BASE + 2, 8'h45);
    expect_byte("R3 window write", 2, 8'h45);

    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule